// File: doc/BRIEF.md
# CAN Fault Confinement Tracker

This block follows the error bookkeeping of one CAN controller. It keeps a transmit error counter and a receive error counter, moves them on strobes from the protocol engine, and derives from them the node's error state: active, warning, passive or bus-off. The counters and the state are shown in a packed 32-bit status word. A capture byte records the details of the most recent bus error. A one-cycle event marks every state change.

Bus-off is sticky. The node leaves it only through a recovery that runs while the controller is out of reset mode. Recovery counts runs of consecutive recessive bits on the bus. When it completes, the node returns to error-active with both counters cleared, and the block requests a drain of transmit entries that were already aborted. Entering bus-off raises an abort request for every transmit slot.

The block does no bit-level protocol work itself. It only consumes strobes that another block produces.

Top module: `can_fault_tracker`

## Requirements
- R1: The status word holds the receive counter in bits [7:0] and the transmit counter in bits [15:8]. A transmit count above 255 is shown as 255. Bit 16 and bits [31:20] read zero.
- R2: A transmit error strobe adds 8 to the transmit counter. A receive error strobe adds 1 to the receive counter, which saturates at 255. A success strobe subtracts 1 and stops at 0. When the error strobe and the success strobe of the same counter arrive together, only the error strobe takes effect.
- R3: The warning state is entered when either counter is at 96 or more. The passive state is entered when either counter is at 128 or more. Bus-off is entered when the transmit counter exceeds 255. Status bit 17 flags warning, bit 18 flags passive and bit 19 flags bus-off. At most one of these bits is set, and the priority is bus-off over passive over warning. `err_state` encodes the state as 0 active, 1 warning, 2 passive, 3 bus-off.
- R4: `state_chg` is high for exactly one clock in the cycle in which the status word and `err_state` first show a new state. It is low in every other cycle.
- R5: While the node is in bus-off, both counters hold their values and all counter strobes are ignored.
- R6: Recovery makes progress only while `reset_mode` is low. Any cycle with `reset_mode` high discards all recovery progress.
- R7: Recovery completes after 128 runs of 11 consecutive recessive `bit_tick` strobes. A dominant tick restarts only the run in progress. Runs already counted are kept.
- R8: On the tick that completes recovery, the node becomes error-active in the next status word, both counters read zero even if a strobe arrives in that cycle, and `drain_req` is high for that one cycle.
- R9: In the cycle in which bus-off first appears, `abort_slots` is all ones across its 16 bits. In every other cycle it is zero.
- R10: On `berr_valid`, the capture byte loads the segment in bits [4:0], the direction in bit 5 (1 means the error happened while transmitting) and the type in bits [7:6] (00 bit, 01 form, 10 stuff, 11 other). Without `berr_valid` the capture byte holds its value.
- R11: After reset, the counters, the capture byte and all events are zero, and the state is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_mode | input | 1 | Controller held in reset mode; blocks bus-off recovery |
| tx_err_inc | input | 1 | Transmit error strobe (+8) |
| tx_ok_dec | input | 1 | Successful transmit strobe (-1) |
| rx_err_inc | input | 1 | Receive error strobe (+1) |
| rx_ok_dec | input | 1 | Successful receive strobe (-1) |
| bit_tick | input | 1 | One strobe per sampled bus bit |
| bit_recessive | input | 1 | Level of the sampled bit, 1 for recessive |
| berr_valid | input | 1 | Bus error detail present |
| berr_seg | input | 5 | Frame segment in which the error happened |
| berr_tx | input | 1 | Error happened while transmitting |
| berr_kind | input | 2 | Error type: 0 bit, 1 form, 2 stuff, 3 other |
| status_word | output | 32 | Packed counters and state flags |
| err_state | output | 2 | Encoded error state |
| state_chg | output | 1 | One-cycle pulse on every state change |
| err_capture | output | 8 | Details of the last bus error |
| drain_req | output | 1 | One-cycle request to flush aborted transmit entries |
| abort_slots | output | 16 | One-cycle abort request, one bit per transmit slot |

## Verification
Two functions can fall in the same cycle. The tick that completes recovery can coincide with a counter strobe. Counter clearing must then win over the error increment, and the state-change event and the drain request must appear together. The bench provokes this by asserting `tx_err_inc` and `rx_err_inc` on exactly the last recessive tick of the 128th run. Before that tick it has already broken recovery once with `reset_mode` and once with a dominant bit. A behavioural model, driven by the same inputs, decides each cycle whether the node should be active with zero counters. The status word, the event and the drain pulse are compared against that model on every clock, and explicit checks confirm the outcome on the completing tick.

// File: rtl/can_fc_pkg.sv
`timescale 1ns/1ps
package can_fc_pkg;

  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'd0,
    FC_WARNING = 2'd1,
    FC_PASSIVE = 2'd2,
    FC_BUSOFF  = 2'd3
  } fc_state_e;

  localparam int TEC_W = 9;   // one bit of headroom beyond 255 marks bus-off
  localparam int REC_W = 8;

  // Transmit counter step: error has priority over success
  function automatic logic [TEC_W-1:0] fc_tec_step(
    input logic [TEC_W-1:0] tec, input logic inc, input logic dec,
    input int unsigned step);
    logic [TEC_W:0] sum;
    sum = {1'b0, tec} + (TEC_W+1)'(step);
    if (inc)                  return sum[TEC_W-1:0];
    else if (dec && tec != 0) return tec - 1'b1;
    else                      return tec;
  endfunction

  // Receive counter step: saturating at the top, floored at zero
  function automatic logic [REC_W-1:0] fc_rec_step(
    input logic [REC_W-1:0] rec, input logic inc, input logic dec);
    if (inc)                  return (&rec) ? rec : rec + 1'b1;
    else if (dec && rec != 0) return rec - 1'b1;
    else                      return rec;
  endfunction

  // State decode with bus-off over passive over warning
  function automatic fc_state_e fc_decode(
    input logic [TEC_W-1:0] tec, input logic [REC_W-1:0] rec,
    input int unsigned warn_lim, input int unsigned pass_lim);
    if (tec > 255)                                    return FC_BUSOFF;
    else if (tec >= pass_lim || rec >= pass_lim)      return FC_PASSIVE;
    else if (tec >= warn_lim || rec >= warn_lim)      return FC_WARNING;
    else                                              return FC_ACTIVE;
  endfunction

  function automatic logic [31:0] fc_pack_status(
    input fc_state_e st, input logic [TEC_W-1:0] tec, input logic [REC_W-1:0] rec);
    logic [7:0] tec_shown;
    tec_shown = (tec > 255) ? 8'hFF : tec[7:0];
    return {12'd0, st == FC_BUSOFF, st == FC_PASSIVE, st == FC_WARNING, 1'b0,
            tec_shown, rec};
  endfunction

  function automatic logic [7:0] fc_pack_capture(
    input logic [4:0] seg, input logic tx, input logic [1:0] kind);
    return {kind, tx, seg};
  endfunction

endpackage

// File: rtl/fc_counters.sv
`timescale 1ns/1ps
module fc_counters
  import can_fc_pkg::*;
#(
  parameter int unsigned TX_STEP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freeze,
  input  logic             clear,
  input  logic             tx_err,
  input  logic             tx_ok,
  input  logic             rx_err,
  input  logic             rx_ok,
  output logic [TEC_W-1:0] tec_q,
  output logic [REC_W-1:0] rec_q,
  output logic [TEC_W-1:0] tec_d,
  output logic [REC_W-1:0] rec_d
);

  always_comb begin
    if (clear) begin
      tec_d = '0;
      rec_d = '0;
    end else if (freeze) begin
      tec_d = tec_q;
      rec_d = rec_q;
    end else begin
      tec_d = fc_tec_step(tec_q, tx_err, tx_ok, TX_STEP);
      rec_d = fc_rec_step(rec_q, rx_err, rx_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tec_q <= '0;
      rec_q <= '0;
    end else begin
      tec_q <= tec_d;
      rec_q <= rec_d;
    end
  end

  AST_REC_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ok && !rx_err && !freeze && !clear && rec_q == 0) |=> rec_q == 0) // R2
    else $error("receive counter wrapped below zero");

  AST_REC_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_err && !freeze && !clear && &rec_q) |=> &rec_q) // R2
    else $error("receive counter wrapped above 255");

endmodule

// File: rtl/fc_recovery.sv
`timescale 1ns/1ps
module fc_recovery #(
  parameter int unsigned RUN_LEN   = 11,
  parameter int unsigned IDLE_RUNS = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic bit_tick,
  input  logic bit_recessive,
  output logic done
);

  localparam int RUN_W  = $clog2(RUN_LEN);
  localparam int IDLE_W = $clog2(IDLE_RUNS + 1);
  localparam logic [RUN_W-1:0]  RUN_LAST  = RUN_W'(RUN_LEN - 1);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(IDLE_RUNS - 1);

  logic [RUN_W-1:0]  run_q;
  logic [IDLE_W-1:0] idle_q;
  logic              run_end;   // an idle condition completes this cycle

  assign run_end = armed && bit_tick && bit_recessive && (run_q == RUN_LAST);
  assign done    = run_end && (idle_q == IDLE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      idle_q <= '0;
    end else if (!armed) begin
      run_q  <= '0;
      idle_q <= '0;
    end else if (bit_tick) begin
      if (!bit_recessive) begin
        run_q <= '0;
      end else if (run_end) begin
        run_q  <= '0;
        idle_q <= idle_q + 1'b1;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  AST_DISARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> (run_q == 0 && idle_q == 0)) // R6
    else $error("recovery progress kept while disarmed");

  AST_DOMINANT_KEEPS_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && bit_tick && !bit_recessive) |=> (run_q == 0 && $stable(idle_q))) // R7
    else $error("dominant bit mishandled");

endmodule

// File: rtl/fc_capture.sv
`timescale 1ns/1ps
module fc_capture
  import can_fc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       berr_valid,
  input  logic [4:0] berr_seg,
  input  logic       berr_tx,
  input  logic [1:0] berr_kind,
  output logic [7:0] cap_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cap_q <= '0;
    else if (berr_valid) cap_q <= fc_pack_capture(berr_seg, berr_tx, berr_kind);
  end

  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !berr_valid |=> $stable(cap_q)) // R10
    else $error("capture byte changed without an error");

endmodule

// File: rtl/can_fault_tracker.sv
`timescale 1ns/1ps
module can_fault_tracker
  import can_fc_pkg::*;
#(
  parameter int unsigned WARN_LIMIT    = 96,
  parameter int unsigned PASSIVE_LIMIT = 128,
  parameter int unsigned TX_STEP       = 8,
  parameter int unsigned RUN_LEN       = 11,
  parameter int unsigned IDLE_RUNS     = 128,
  parameter int unsigned TX_SLOTS      = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reset_mode,
  input  logic                tx_err_inc,
  input  logic                tx_ok_dec,
  input  logic                rx_err_inc,
  input  logic                rx_ok_dec,
  input  logic                bit_tick,
  input  logic                bit_recessive,
  input  logic                berr_valid,
  input  logic [4:0]          berr_seg,
  input  logic                berr_tx,
  input  logic [1:0]          berr_kind,
  output logic [31:0]         status_word,
  output logic [1:0]          err_state,
  output logic                state_chg,
  output logic [7:0]          err_capture,
  output logic                drain_req,
  output logic [TX_SLOTS-1:0] abort_slots
);

  fc_state_e        state_q, state_d;
  logic [TEC_W-1:0] tec_q, tec_d;
  logic [REC_W-1:0] rec_q, rec_d;
  logic             in_busoff;
  logic             recov_armed;
  logic             recov_done;
  logic             enter_busoff;

  assign in_busoff   = (state_q == FC_BUSOFF);
  assign recov_armed = in_busoff && !reset_mode;

  fc_counters #(.TX_STEP(TX_STEP)) u_counters (
    .clk    (clk),
    .rst_n  (rst_n),
    .freeze (in_busoff),
    .clear  (recov_done),
    .tx_err (tx_err_inc),
    .tx_ok  (tx_ok_dec),
    .rx_err (rx_err_inc),
    .rx_ok  (rx_ok_dec),
    .tec_q  (tec_q),
    .rec_q  (rec_q),
    .tec_d  (tec_d),
    .rec_d  (rec_d)
  );

  fc_recovery #(.RUN_LEN(RUN_LEN), .IDLE_RUNS(IDLE_RUNS)) u_recovery (
    .clk           (clk),
    .rst_n         (rst_n),
    .armed         (recov_armed),
    .bit_tick      (bit_tick),
    .bit_recessive (bit_recessive),
    .done          (recov_done)
  );

  fc_capture u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .berr_valid (berr_valid),
    .berr_seg   (berr_seg),
    .berr_tx    (berr_tx),
    .berr_kind  (berr_kind),
    .cap_q      (err_capture)
  );

  always_comb begin
    if (in_busoff) state_d = recov_done ? FC_ACTIVE : FC_BUSOFF;
    else           state_d = fc_decode(tec_d, rec_d, WARN_LIMIT, PASSIVE_LIMIT);
  end

  assign enter_busoff = (state_d == FC_BUSOFF) && !in_busoff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= FC_ACTIVE;
      state_chg   <= 1'b0;
      drain_req   <= 1'b0;
      abort_slots <= '0;
    end else begin
      state_q     <= state_d;
      state_chg   <= (state_d != state_q);
      drain_req   <= recov_done;
      abort_slots <= {TX_SLOTS{enter_busoff}};
    end
  end

  assign status_word = fc_pack_status(state_q, tec_q, rec_q);
  assign err_state   = state_q;

  AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status_word[19:17])) // R3
    else $error("more than one state flag set");

  AST_BUSOFF_TEC: assert property (@(posedge clk) disable iff (!rst_n)
    in_busoff |-> tec_q > 255) // R3
    else $error("bus-off without transmit overflow");

  AST_BUSOFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_busoff && !recov_done) |=> ($stable(tec_q) && $stable(rec_q))) // R5
    else $error("counter moved in bus-off");

  AST_CHG_MEANS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    state_chg |-> state_q != $past(state_q)) // R4
    else $error("event without a state change");

  AST_NEW_MEANS_CHG: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != $past(state_q)) |-> state_chg) // R4
    else $error("state change without event");

  AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == FC_BUSOFF && !in_busoff) |-> (tec_q == 0 && rec_q == 0 && drain_req)) // R8
    else $error("bus-off exit without clear and drain");

  AST_ABORT_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_slots != 0) |-> (&abort_slots && in_busoff && state_chg)) // R9
    else $error("abort request outside bus-off entry");

endmodule

// File: tb/test_can_fault_tracker.sv
`timescale 1ns/1ps
module test_can_fault_tracker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reset_mode = 1'b0;
  logic        tx_err_inc = 1'b0, tx_ok_dec = 1'b0, rx_err_inc = 1'b0, rx_ok_dec = 1'b0;
  logic        bit_tick = 1'b0, bit_recessive = 1'b1;
  logic        berr_valid = 1'b0;
  logic [4:0]  berr_seg = '0;
  logic        berr_tx = 1'b0;
  logic [1:0]  berr_kind = '0;
  logic [31:0] status_word;
  logic [1:0]  err_state;
  logic        state_chg;
  logic [7:0]  err_capture;
  logic        drain_req;
  logic [15:0] abort_slots;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  can_fault_tracker i_can_fault_tracker (
    .clk(clk), .rst_n(rst_n), .reset_mode(reset_mode),
    .tx_err_inc(tx_err_inc), .tx_ok_dec(tx_ok_dec),
    .rx_err_inc(rx_err_inc), .rx_ok_dec(rx_ok_dec),
    .bit_tick(bit_tick), .bit_recessive(bit_recessive),
    .berr_valid(berr_valid), .berr_seg(berr_seg), .berr_tx(berr_tx), .berr_kind(berr_kind),
    .status_word(status_word), .err_state(err_state), .state_chg(state_chg),
    .err_capture(err_capture), .drain_req(drain_req), .abort_slots(abort_slots)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_tx, m_rx, m_st, m_run, m_idle, m_cap;
  bit m_chg, m_drain, m_abort;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tx = 0; m_rx = 0; m_st = 0; m_run = 0; m_idle = 0; m_cap = 0;
      m_chg = 0; m_drain = 0; m_abort = 0;
    end else begin
      bit done;
      int ns;
      done = 0;
      if (!(m_st == 3 && !reset_mode)) begin
        m_run = 0; m_idle = 0;
      end else if (bit_tick) begin
        if (!bit_recessive) m_run = 0;
        else begin
          m_run++;
          if (m_run == 11) begin
            m_run = 0; m_idle++;
            if (m_idle == 128) done = 1;
          end
        end
      end
      if (m_st == 3) begin
        if (done) begin m_tx = 0; m_rx = 0; ns = 0; end
        else ns = 3;
      end else begin
        if (tx_err_inc) m_tx += 8; else if (tx_ok_dec && m_tx > 0) m_tx--;
        if (rx_err_inc) begin if (m_rx < 255) m_rx++; end
        else if (rx_ok_dec && m_rx > 0) m_rx--;
        if (m_tx > 255) ns = 3;
        else if (m_tx >= 128 || m_rx >= 128) ns = 2;
        else if (m_tx >= 96 || m_rx >= 96) ns = 1;
        else ns = 0;
      end
      m_chg = (ns != m_st);
      m_abort = (ns == 3 && m_st != 3);
      m_drain = done;
      m_st = ns;
      if (berr_valid) m_cap = berr_kind * 64 + berr_tx * 32 + berr_seg;
    end
  end

  function automatic longint model_status();
    int t;
    t = (m_tx > 255) ? 255 : m_tx;
    return longint'((m_st == 3) << 19) | longint'((m_st == 2) << 18) |
           longint'((m_st == 1) << 17) | longint'(t << 8) | longint'(m_rx);
  endfunction

  // Per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(status_word == model_status(), "R1 R3 status word", status_word, model_status());
      check(err_state == m_st, "R3 state", err_state, m_st);
      check(state_chg == m_chg, "R4 event", state_chg, m_chg);
      check(drain_req == m_drain, "R8 drain", drain_req, m_drain);
      check(abort_slots == (m_abort ? 16'hFFFF : 16'h0), "R9 abort", abort_slots, m_abort ? 16'hFFFF : 0);
      check(err_capture == m_cap, "R10 capture", err_capture, m_cap);
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    // R11 reset state
    check(status_word == 0 && err_state == 0, "R11 reset status", status_word, 0);
    check(err_capture == 0 && !state_chg && !drain_req && abort_slots == 0, "R11 reset events", err_capture, 0);

    // Receive side thresholds
    rx_err_inc = 1; cycles(96); rx_err_inc = 0;
    check(err_state == 1 && state_chg, "R3 warning at 96", err_state, 1);
    cycles(1);
    check(!state_chg, "R4 single pulse", state_chg, 0);
    rx_err_inc = 1; cycles(32); rx_err_inc = 0;
    check(err_state == 2 && status_word[7:0] == 128, "R3 passive at 128", status_word, 32'h4_0080);
    rx_ok_dec = 1; cycles(1); rx_ok_dec = 0;
    check(err_state == 1 && status_word[7:0] == 127, "R2 decrement", status_word[7:0], 127);
    rx_err_inc = 1; cycles(200); rx_err_inc = 0;
    check(status_word[7:0] == 255, "R2 saturation", status_word[7:0], 255);
    rx_ok_dec = 1; cycles(260); rx_ok_dec = 0;
    check(status_word[7:0] == 0 && err_state == 0, "R2 floor", status_word[7:0], 0);
    rx_err_inc = 1; rx_ok_dec = 1; cycles(3); rx_err_inc = 0; rx_ok_dec = 0;
    check(status_word[7:0] == 3, "R2 inc wins", status_word[7:0], 3);

    // Transmit side and bus-off entry
    tx_err_inc = 1; cycles(12); tx_err_inc = 0;
    check(err_state == 1 && status_word[15:8] == 96, "R3 tx warning", status_word, 32'h2_6003);
    tx_ok_dec = 1; cycles(1); tx_ok_dec = 0;
    check(err_state == 0 && status_word[15:8] == 95, "R2 tx decrement", status_word[15:8], 95);
    reset_mode = 1;
    tx_err_inc = 1; cycles(21); tx_err_inc = 0;
    check(err_state == 3 && status_word == 32'h8_FF03, "R1 R3 bus-off status", status_word, 32'h8_FF03);
    check(abort_slots == 16'hFFFF && state_chg, "R9 abort on entry", abort_slots, 16'hFFFF);
    cycles(1);
    check(abort_slots == 0 && !state_chg, "R9 abort single cycle", abort_slots, 0);

    // Bus-off held in reset mode, strobes ignored
    bit_tick = 1; bit_recessive = 1; tx_err_inc = 1; rx_err_inc = 1;
    cycles(2000);
    tx_err_inc = 0; rx_err_inc = 0;
    check(err_state == 3, "R6 no recovery in reset mode", err_state, 3);
    check(status_word[7:0] == 3, "R5 counters frozen", status_word[7:0], 3);

    // Recovery interrupted by reset mode
    reset_mode = 0; cycles(700);
    reset_mode = 1; cycles(1);
    reset_mode = 0; cycles(1407);
    check(err_state == 3, "R6 progress discarded", err_state, 3);
    bit_recessive = 0; cycles(1);
    bit_recessive = 1; cycles(10);
    check(err_state == 3, "R7 dominant restarts run", err_state, 3);
    // Completing tick coincides with error strobes
    tx_err_inc = 1; rx_err_inc = 1; cycles(1); tx_err_inc = 0; rx_err_inc = 0;
    check(err_state == 0 && state_chg, "R8 back to active", err_state, 0);
    check(status_word == 0, "R8 counters cleared", status_word, 0);
    check(drain_req, "R8 drain pulse", drain_req, 1);
    cycles(1);
    check(!drain_req, "R8 drain single cycle", drain_req, 0);
    bit_tick = 0;

    // Capture byte
    berr_seg = 5'h1A; berr_tx = 1; berr_kind = 2'd2; berr_valid = 1; cycles(1); berr_valid = 0;
    check(err_capture == 8'hBA, "R10 stuff while transmitting", err_capture, 8'hBA);
    berr_seg = 5'h03; berr_tx = 0; berr_kind = 2'd3; cycles(2);
    check(err_capture == 8'hBA, "R10 hold without valid", err_capture, 8'hBA);
    berr_valid = 1; cycles(1); berr_valid = 0;
    check(err_capture == 8'hC3, "R10 other while receiving", err_capture, 8'hC3);
    berr_seg = 5'h11; berr_kind = 2'd1; berr_valid = 1; cycles(1); berr_valid = 0;
    check(err_capture == 8'h51, "R10 form error", err_capture, 8'h51);
    cycles(2);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule